// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits between the fetch and decode stages of a five-stage in-order pipeline. It holds the program counter, the fetch/decode pipeline register and the decode/execute pipeline register. Its job is to spot one case: a load in the execute stage whose destination register is needed as a source by the instruction now in decode. Forwarding cannot cover this case, because the loaded value does not exist until the memory stage has run.

When that case occurs, the block does three things in the same cycle. It drops the program-counter write enable and the fetch/decode write enable, so the fetched instruction and the dependent instruction both stay where they are. It also selects an all-zero control bundle, and an all-zero instruction word, into the decode/execute register. That slot becomes a bubble. On the next edge the load has moved on to the memory stage, the condition no longer holds, and the pipeline advances normally. The dependent instruction therefore enters execute exactly one cycle later than it would have without the hazard.

Every other dependency is left to the forwarding network, which lies outside this block. The instruction memory and the decoder also lie outside it. The decoder supplies the control bundle for the instruction held in decode.

Top module: `lu_stall_top`

## Requirements
- R1: While reset is low, the program counter, the fetch/decode instruction, the execute instruction, the execute control bundle and the execute destination field all read zero. Both write enables read high and the bubble select reads low.
- R2: A stall is flagged in the same cycle when three things hold: memory-read (bit 1 of the execute control bundle) is set, the execute destination field (bits 20:16 of the instruction that entered execute) is non-zero, and that field equals either source field of the decode instruction (bits 25:21 or bits 20:16). During a stall, pcWrite and ifIdWrite are low and bubbleSel is high.
- R3: On a stall cycle the program counter does not change at the next edge.
- R4: On a stall cycle the fetch/decode instruction does not change at the next edge.
- R5: After a stall cycle, the execute stage holds a bubble. Its control bundle, instruction word and destination field are all zero, so it performs no register write and no memory access.
- R6: A load whose destination field is register 0 never causes a stall, even when a source field of the decode instruction matches it.
- R7: No stall occurs when the execute instruction is not a load, even when its destination field matches a decode source field. No stall occurs when a load's destination matches neither source field.
- R8: Each stall lasts exactly one cycle. The dependent instruction reaches execute one cycle later than it would have without the hazard. Back-to-back dependent loads each add one bubble.
- R9: On every cycle without a stall, the program counter advances by 4. The decode/execute register takes the decoded control bundle, the decode instruction and its bits 20:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchInstr | input | 32 | Instruction word read at the current program counter |
| idCtrl | input | 8 | Decoded control bundle for the decode instruction: bit0 register write, bit1 memory read, bit2 memory write, bit3 memory-to-register, bit4 ALU immediate, bit5 destination select, bits 7:6 ALU operation |
| pcOut | output | 32 | Program counter |
| idInstr | output | 32 | Fetch/decode pipeline register contents |
| exInstr | output | 32 | Instruction word held in the decode/execute register |
| exCtrl | output | 8 | Control bundle held in the decode/execute register |
| exRt | output | 5 | Destination field held in the decode/execute register |
| pcWrite | output | 1 | Program counter write enable |
| ifIdWrite | output | 1 | Fetch/decode register write enable |
| bubbleSel | output | 1 | High when a zero bundle is selected into the decode/execute register |

## Verification
The stall strobes are combinational, so they are due in the same cycle that a load sits in execute and its consumer sits in decode. The frozen program counter, the frozen decode word and the bubble all appear one edge later. After reset is released, the first program instruction reaches execute on the second rising edge. The scoreboard builds one expected execute-stage slot per cycle, each with its strobes, program counter and decode word. It inserts a bubble slot after each expected load-use pair. It compares one slot at each falling edge, starting after that second rising edge, so a missing or extra stall cycle shifts every later slot and is reported.

// File: rtl/lu_pkg.sv
package lu_pkg;

  // Control bundle carried from decode into execute; bit 0 is regWrite.
  typedef struct packed {
    logic [1:0] aluOp;
    logic       regDst;
    logic       aluSrc;
    logic       memToReg;
    logic       memWrite;
    logic       memRead;
    logic       regWrite;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Strobes from the hazard control to the pipeline registers.
  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic bubble;
  } strobe_t;

endpackage

// File: rtl/lu_ctrl.sv
module lu_ctrl
  import lu_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            exMemRead,
  input  logic [REG_W-1:0]                exDest,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   srcRegs,
  output strobe_t                         strobe
);

  logic [NUM_SRC-1:0] srcHit;
  logic               destLive;
  logic               loadUse;

  // One equality comparator per decode source field.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign srcHit[g] = (srcRegs[g] == exDest);
  end

  // Register zero is hard-wired, so it never carries a dependency.
  assign destLive = (exDest != '0);
  assign loadUse  = exMemRead && destLive && (|srcHit);

  always_comb begin
    strobe.pcWrite   = !loadUse;
    strobe.ifIdWrite = !loadUse;
    strobe.bubble    = loadUse;
  end

endmodule

// File: rtl/lu_datapath.sv
module lu_datapath
  import lu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_W   = 5,
  parameter int RT_LSB  = 16,
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [XLEN-1:0]  fetchInstr,
  input  ctrl_t            idCtrl,
  output logic [XLEN-1:0]  pcQ,
  output logic [XLEN-1:0]  idInstrQ,
  output logic [XLEN-1:0]  exInstrQ,
  output ctrl_t            exCtrlQ,
  output logic [REG_W-1:0] exRtQ
);

  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  // Program counter
  always_ff @(posedge clk) begin
    if (!rstN)               pcQ <= '0;
    else if (strobe.pcWrite) pcQ <= pcQ + STEP;
  end

  // Fetch/decode register; zero is the no-op encoding.
  always_ff @(posedge clk) begin
    if (!rstN)                 idInstrQ <= '0;
    else if (strobe.ifIdWrite) idInstrQ <= fetchInstr;
  end

  // Decode/execute register with bubble mux.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.bubble) begin
      exInstrQ <= '0;
      exCtrlQ  <= '0;
      exRtQ    <= '0;
    end else begin
      exInstrQ <= idInstrQ;
      exCtrlQ  <= idCtrl;
      exRtQ    <= idInstrQ[RT_LSB +: REG_W];
    end
  end

endmodule

// File: rtl/lu_stall_top.sv
module lu_stall_top
  import lu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_W   = 5,
  parameter int RS_LSB  = 21,
  parameter int RT_LSB  = 16,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [XLEN-1:0]   fetchInstr,
  input  logic [CTRL_W-1:0] idCtrl,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   idInstr,
  output logic [XLEN-1:0]   exInstr,
  output logic [CTRL_W-1:0] exCtrl,
  output logic [REG_W-1:0]  exRt,
  output logic              pcWrite,
  output logic              ifIdWrite,
  output logic              bubbleSel
);

  localparam int NUM_SRC = 2;

  strobe_t                       strobe;
  ctrl_t                         idCtrlS;
  ctrl_t                         exCtrlS;
  logic [NUM_SRC-1:0][REG_W-1:0] srcRegs;

  assign idCtrlS    = ctrl_t'(idCtrl);
  assign srcRegs[0] = idInstr[RS_LSB +: REG_W];
  assign srcRegs[1] = idInstr[RT_LSB +: REG_W];

  lu_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_ctrl (
    .exMemRead (exCtrlS.memRead),
    .exDest    (exRt),
    .srcRegs   (srcRegs),
    .strobe    (strobe)
  );

  lu_datapath #(
    .XLEN(XLEN), .REG_W(REG_W), .RT_LSB(RT_LSB), .PC_STEP(PC_STEP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fetchInstr (fetchInstr),
    .idCtrl     (idCtrlS),
    .pcQ        (pcOut),
    .idInstrQ   (idInstr),
    .exInstrQ   (exInstr),
    .exCtrlQ    (exCtrlS),
    .exRtQ      (exRt)
  );

  assign exCtrl    = exCtrlS;
  assign pcWrite   = strobe.pcWrite;
  assign ifIdWrite = strobe.ifIdWrite;
  assign bubbleSel = strobe.bubble;

endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk #(
  parameter int XLEN   = 32,
  parameter int REG_W  = 5,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [XLEN-1:0]   pcOut,
  input logic [XLEN-1:0]   idInstr,
  input logic [XLEN-1:0]   exInstr,
  input logic [CTRL_W-1:0] exCtrl,
  input logic [REG_W-1:0]  exRt,
  input logic              pcWrite,
  input logic              ifIdWrite,
  input logic              bubbleSel
);

  localparam int MEMREAD_BIT = 1;

  a_r2_strobes_agree: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite == ifIdWrite) && (bubbleSel == !pcWrite));

  a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !pcWrite |=> $stable(pcOut));

  a_r4_ifid_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ifIdWrite |=> $stable(idInstr));

  a_r5_bubble_empty: assert property (@(posedge clk) disable iff (!rstN)
    bubbleSel |=> (exCtrl == '0) && (exInstr == '0) && (exRt == '0));

  a_r6_zero_dest: assert property (@(posedge clk) disable iff (!rstN)
    (exRt == '0) |-> !bubbleSel);

  a_r7_nonload_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !exCtrl[MEMREAD_BIT] |-> !bubbleSel);

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    bubbleSel |=> !bubbleSel);

  a_r9_pc_advance: assert property (@(posedge clk) disable iff (!rstN)
    pcWrite |=> (pcOut == $past(pcOut) + XLEN'(4)));

endmodule

bind lu_stall_top lu_stall_chk #(.XLEN(XLEN), .REG_W(REG_W), .CTRL_W(lu_pkg::CTRL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pcOut     (pcOut),
  .idInstr   (idInstr),
  .exInstr   (exInstr),
  .exCtrl    (exCtrl),
  .exRt      (exRt),
  .pcWrite   (pcWrite),
  .ifIdWrite (ifIdWrite),
  .bubbleSel (bubbleSel)
);

// File: tb/tb_lu_stall_top.sv
`timescale 1ns/1ps
module tb_lu_stall_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchInstr;
  logic [7:0]  idCtrl;
  logic [31:0] pcOut, idInstr, exInstr;
  logic [7:0]  exCtrl;
  logic [4:0]  exRt;
  logic        pcWrite, ifIdWrite, bubbleSel;

  always #10 clk = ~clk;  // 50 MHz

  lu_stall_top dut (
    .clk(clk), .rstN(rstN), .fetchInstr(fetchInstr), .idCtrl(idCtrl),
    .pcOut(pcOut), .idInstr(idInstr), .exInstr(exInstr), .exCtrl(exCtrl),
    .exRt(exRt), .pcWrite(pcWrite), .ifIdWrite(ifIdWrite), .bubbleSel(bubbleSel)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] prog [32];
  logic monOn = 1'b0;

  typedef struct {
    logic [31:0] ex;
    logic [31:0] id;
    logic [31:0] pc;
    logic [7:0]  ctl;
    logic [4:0]  rt;
    logic        stall;
    logic        bub;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  function automatic logic [31:0] lwI(input int rt, input int base);
    return {6'h23, 5'(base), 5'(rt), 16'h0};
  endfunction
  function automatic logic [31:0] swI(input int rt, input int base);
    return {6'h2b, 5'(base), 5'(rt), 16'h0};
  endfunction
  function automatic logic [31:0] addI(input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, 6'h20};
  endfunction

  // Decoder model, out of scope for the block.
  function automatic logic [7:0] decode(input logic [31:0] ins);
    if (ins == 32'h0)               return 8'h00;
    else if (ins[31:26] == 6'h23)   return 8'h1B;
    else if (ins[31:26] == 6'h2b)   return 8'h14;
    else if (ins[31:26] == 6'h00)   return 8'hA1;
    else                            return 8'h00;
  endfunction

  function automatic logic [31:0] progAt(input int i);
    return (i >= 0 && i < 32) ? prog[i] : 32'h0;
  endfunction

  always_comb begin
    fetchInstr = (pcOut < 32'd128) ? prog[pcOut[6:2]] : 32'h0;
    idCtrl     = decode(idInstr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: expected execute-stage slots, one per cycle.
  task automatic pushProgram(input string tag, input int n);
    for (int i = 0; i < n + 2; i++) begin
      exp_t it;
      logic [31:0] ins, nxt;
      logic hz;
      ins = progAt(i);
      nxt = progAt(i + 1);
      hz  = (ins[31:26] == 6'h23) && (ins[20:16] != 5'd0) &&
            ((nxt[25:21] == ins[20:16]) || (nxt[20:16] == ins[20:16]));
      it.ex = ins; it.id = nxt; it.pc = 32'((i + 2) * 4);
      it.ctl = decode(ins); it.rt = ins[20:16];
      it.stall = hz; it.bub = 1'b0; it.tag = tag;
      expQ.push_back(it);
      if (hz) begin
        it.ex = 32'h0; it.ctl = 8'h0; it.rt = 5'h0;
        it.stall = 1'b0; it.bub = 1'b1;
        expQ.push_back(it);
      end
    end
  endtask

  // Monitor: one slot per falling edge.
  always @(negedge clk) begin
    if (monOn && expQ.size() > 0) begin
      exp_t e;
      string sreq;
      e = expQ.pop_front();
      sreq = e.stall ? "R2" : e.tag;
      check(exInstr == e.ex, e.bub ? "R5" : e.tag, "exInstr", exInstr, e.ex);
      check(exCtrl == e.ctl, e.bub ? "R5" : e.tag, "exCtrl", {24'h0, exCtrl}, {24'h0, e.ctl});
      check(exRt == e.rt, e.bub ? "R5" : "R9", "exRt", {27'h0, exRt}, {27'h0, e.rt});
      check(pcOut == e.pc, e.bub ? "R3" : "R9", "pcOut", pcOut, e.pc);
      check(idInstr == e.id, e.bub ? "R4" : "R9", "idInstr", idInstr, e.id);
      check(pcWrite == !e.stall, sreq, "pcWrite", {31'h0, pcWrite}, {31'h0, !e.stall});
      check(ifIdWrite == !e.stall, sreq, "ifIdWrite", {31'h0, ifIdWrite}, {31'h0, !e.stall});
      check(bubbleSel == e.stall, sreq, "bubbleSel", {31'h0, bubbleSel}, {31'h0, e.stall});
    end
  end

  task automatic runProgram(input string tag, input int n);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pcOut == 0 && idInstr == 0 && exInstr == 0, "R1", "pc/id/ex",
          pcOut | idInstr | exInstr, 32'h0);
    check(exCtrl == 0 && exRt == 0, "R1", "exCtrl/exRt", {19'h0, exCtrl, exRt}, 32'h0);
    check(pcWrite && ifIdWrite && !bubbleSel, "R1", "strobes",
          {29'h0, pcWrite, ifIdWrite, bubbleSel}, 32'h6);
    pushProgram(tag, n);
    rstN = 1'b1;
    @(posedge clk);
    @(posedge clk);
    monOn = 1'b1;
    while (expQ.size() != 0) @(posedge clk);
    monOn = 1'b0;
  endtask

  task automatic clearProg();
    for (int k = 0; k < 32; k++) prog[k] = 32'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R8: load then rs-dependent add; dependent arrives one cycle late
    clearProg();
    prog[0] = lwI(5, 1); prog[1] = addI(7, 5, 6);
    prog[2] = addI(8, 2, 3); prog[3] = swI(7, 8);
    runProgram("R8", 4);

    // R2: dependency through the rt field
    clearProg();
    prog[0] = lwI(9, 2); prog[1] = addI(10, 2, 9); prog[2] = addI(11, 10, 1);
    runProgram("R2", 3);

    // R6: load into register zero never stalls
    clearProg();
    prog[0] = lwI(0, 1); prog[1] = addI(3, 0, 0); prog[2] = swI(0, 0);
    runProgram("R6", 3);

    // R7: ALU dependency and unrelated load, no stall
    clearProg();
    prog[0] = addI(5, 1, 2); prog[1] = addI(6, 5, 5);
    prog[2] = lwI(4, 3); prog[3] = addI(7, 1, 2); prog[4] = swI(5, 6);
    runProgram("R7", 5);

    // R8: chained loads, each adds one bubble; store uses loaded base
    clearProg();
    prog[0] = lwI(5, 1); prog[1] = lwI(6, 5); prog[2] = addI(7, 6, 6);
    prog[3] = lwI(8, 2); prog[4] = swI(3, 8); prog[5] = addI(9, 8, 0);
    runProgram("R8", 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule